// File: doc/BRIEF.md
# Plane-Aware Busy Status Generator

This block forms the word returned on a read of a two-plane flash while an embedded program or erase is under way. For each read it looks at the mode of the plane that the read address falls in (idle, programming, erasing, or holding a suspended erase) and decides between passing the true array word through and replacing it with a status word. The status word carries a polarity flag on bit 7, a toggle flag on bit 6 that flips on every completed read of the busy plane, and a second toggle flag on bit 2 that marks an erase and the suspended sector.

Software polls the device by reading repeatedly. A read of the other plane is never disturbed, so code can keep running from one plane while the other is written. An active-low ready/busy line is modelled as an output enable that is high while any plane is actively programming or erasing. Command decoding, the array and the operation timers sit outside this block and drive its inputs.

Top module: `emb_status_gen`

## Requirements
- R1: While the read plane is programming (mode code 1), bit 7 of the read word is the inverse of bit 7 of the last programmed word, and bit 2 reads 1.
- R2: While the read plane is erasing (mode code 2), bit 7 of the read word is 0.
- R3: While the read plane is programming or erasing, bit 6 inverts after each completed read strobe in that plane; a strobe addressed to another plane leaves it unchanged.
- R4: While the read plane is erasing, bit 2 inverts after each completed read strobe in that plane, together with bit 6.
- R5: While the read plane holds a suspended erase (mode code 3), a read inside the suspended sector returns 1 on bits 7 and 6 and a bit 2 that inverts after each strobe in that sector; a read elsewhere in that plane returns true array data and does not advance bit 2.
- R6: A read in an idle plane (mode code 0) returns the true array word, including a read issued in the same cycle in which the plane returns to idle.
- R7: The ready/busy enable is 1 whenever any plane is programming or erasing, and 0 when every plane is idle or suspended.
- R8: Toggle state is 0 after reset and is cleared whenever its plane is idle; it is kept across suspend and resume of an erase.
- R9: In every status word, the bits other than 7, 6 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| plane_mode_i | input | 2*NPL | Mode of each plane, 2 bits per plane, plane 0 in the low bits: 0 idle, 1 program, 2 erase, 3 erase suspended |
| rd_plane_i | input | PLW | Plane selected by the current read address |
| rd_in_susp_i | input | 1 | Read address lies in the suspended sector |
| rd_strobe_i | input | 1 | A read completes in this cycle |
| prog_data_i | input | DW | Last word loaded for programming |
| array_data_i | input | DW | True array word at the read address |
| rd_data_o | output | DW | Word returned to the reader |
| rdy_busy_oe_o | output | 1 | 1 pulls the open-drain ready/busy line low |

## Verification
A vector table walks the mode combinations without strobes: each plane idle, programming with bit 7 of the loaded word at 0 and at 1, erasing with an all-ones array word, and suspended with the read inside and outside the suspended sector; these tell the polarity flag apart from a copy of the array word and show that the idle plane is passed through while the other is busy. Directed sequences then strobe reads to show that bit 6 flips only for strobes in the busy plane, that bit 2 flips with bit 6 in an erase but stays 1 in a program, and that the toggles clear on return to idle but survive a suspend and resume.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

    typedef enum logic [1:0] {
        PL_IDLE  = 2'd0,
        PL_PROG  = 2'd1,
        PL_ERASE = 2'd2,
        PL_SUSP  = 2'd3
    } plane_mode_e;

    localparam int MODE_W       = 2;
    localparam int POLL_BIT     = 7;
    localparam int TOG_BIT      = 6;
    localparam int SUSP_TOG_BIT = 2;

    typedef struct packed {
        plane_mode_e mode;
        logic        in_susp;
        logic        tog_main;
        logic        tog_susp;
    } read_ctx_t;

    function automatic logic mode_active(plane_mode_e m);
        return (m == PL_PROG) || (m == PL_ERASE);
    endfunction

    function automatic logic susp_tog_adv(plane_mode_e m, logic in_susp);
        return (m == PL_ERASE) || ((m == PL_SUSP) && in_susp);
    endfunction

endpackage

// File: rtl/emb_toggle_bank.sv
module emb_toggle_bank
    import emb_status_pkg::*;
#(
    parameter int NPL = 2,
    parameter int PLW = 1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [NPL*MODE_W-1:0]   mode_flat_i,
    input  logic [PLW-1:0]          rd_plane_i,
    input  logic                    rd_in_susp_i,
    input  logic                    rd_strobe_i,
    output logic [NPL-1:0]          tog_main_o,
    output logic [NPL-1:0]          tog_susp_o
);

    for (genvar p = 0; p < NPL; p++) begin : g_plane
        plane_mode_e mode;
        logic        hit;
        logic        main_q;
        logic        susp_q;

        assign mode = plane_mode_e'(mode_flat_i[p*MODE_W +: MODE_W]);
        assign hit  = rd_strobe_i && (rd_plane_i == PLW'(p));

        always_ff @(posedge clk_i) begin
            if (rst_i || (mode == PL_IDLE)) begin
                main_q <= 1'b0;
                susp_q <= 1'b0;
            end else if (hit) begin
                if (mode_active(mode))
                    main_q <= ~main_q;
                if (susp_tog_adv(mode, rd_in_susp_i))
                    susp_q <= ~susp_q;
            end
        end

        assign tog_main_o[p] = main_q;
        assign tog_susp_o[p] = susp_q;
    end

endmodule

// File: rtl/emb_busy_detect.sv
module emb_busy_detect
    import emb_status_pkg::*;
#(
    parameter int NPL = 2
) (
    input  logic [NPL*MODE_W-1:0] mode_flat_i,
    output logic                  busy_oe_o
);

    logic [NPL-1:0] active;

    for (genvar p = 0; p < NPL; p++) begin : g_act
        assign active[p] = mode_active(plane_mode_e'(mode_flat_i[p*MODE_W +: MODE_W]));
    end

    assign busy_oe_o = |active;

endmodule

// File: rtl/emb_status_mux.sv
module emb_status_mux
    import emb_status_pkg::*;
#(
    parameter int DW = 16
) (
    input  read_ctx_t       ctx_i,
    input  logic [DW-1:0]   prog_data_i,
    input  logic [DW-1:0]   array_data_i,
    output logic [DW-1:0]   rd_data_o
);

    always_comb begin
        rd_data_o = '0;
        unique case (ctx_i.mode)
            PL_IDLE: rd_data_o = array_data_i;
            PL_PROG: begin
                rd_data_o[POLL_BIT]     = ~prog_data_i[POLL_BIT];
                rd_data_o[TOG_BIT]      = ctx_i.tog_main;
                rd_data_o[SUSP_TOG_BIT] = 1'b1;
            end
            PL_ERASE: begin
                rd_data_o[POLL_BIT]     = 1'b0;
                rd_data_o[TOG_BIT]      = ctx_i.tog_main;
                rd_data_o[SUSP_TOG_BIT] = ctx_i.tog_susp;
            end
            PL_SUSP: begin
                if (ctx_i.in_susp) begin
                    rd_data_o[POLL_BIT]     = 1'b1;
                    rd_data_o[TOG_BIT]      = 1'b1;
                    rd_data_o[SUSP_TOG_BIT] = ctx_i.tog_susp;
                end else begin
                    rd_data_o = array_data_i;
                end
            end
            default: rd_data_o = array_data_i;
        endcase
    end

endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
    import emb_status_pkg::*;
#(
    parameter  int NPL = 2,
    parameter  int DW  = 16,
    localparam int PLW = (NPL > 1) ? $clog2(NPL) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NPL*2-1:0]      plane_mode_i,
    input  logic [PLW-1:0]        rd_plane_i,
    input  logic                  rd_in_susp_i,
    input  logic                  rd_strobe_i,
    input  logic [DW-1:0]         prog_data_i,
    input  logic [DW-1:0]         array_data_i,
    output logic [DW-1:0]         rd_data_o,
    output logic                  rdy_busy_oe_o
);

    logic [NPL-1:0] tog_main;
    logic [NPL-1:0] tog_susp;
    read_ctx_t      ctx;

    emb_toggle_bank #(.NPL(NPL), .PLW(PLW)) i_tog (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .mode_flat_i  (plane_mode_i),
        .rd_plane_i   (rd_plane_i),
        .rd_in_susp_i (rd_in_susp_i),
        .rd_strobe_i  (rd_strobe_i),
        .tog_main_o   (tog_main),
        .tog_susp_o   (tog_susp)
    );

    always_comb begin
        ctx.mode     = plane_mode_e'(plane_mode_i[rd_plane_i*MODE_W +: MODE_W]);
        ctx.in_susp  = rd_in_susp_i;
        ctx.tog_main = tog_main[rd_plane_i];
        ctx.tog_susp = tog_susp[rd_plane_i];
    end

    emb_status_mux #(.DW(DW)) i_mux (
        .ctx_i        (ctx),
        .prog_data_i  (prog_data_i),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o)
    );

    emb_busy_detect #(.NPL(NPL)) i_busy (
        .mode_flat_i (plane_mode_i),
        .busy_oe_o   (rdy_busy_oe_o)
    );

endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk
    import emb_status_pkg::*;
#(
    parameter int NPL = 2,
    parameter int DW  = 16,
    parameter int PLW = 1
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic [NPL*2-1:0]      plane_mode_i,
    input logic [PLW-1:0]        rd_plane_i,
    input logic                  rd_in_susp_i,
    input logic                  rd_strobe_i,
    input logic [DW-1:0]         prog_data_i,
    input logic [DW-1:0]         array_data_i,
    input logic [DW-1:0]         rd_data_o,
    input logic                  rdy_busy_oe_o
);

    plane_mode_e    cur_mode;
    logic           all_quiet;
    logic           prev_hit;
    logic [PLW-1:0] prev_plane;
    plane_mode_e    prev_mode;
    logic           prev_b6;

    assign cur_mode  = plane_mode_e'(plane_mode_i[rd_plane_i*2 +: 2]);

    always_comb begin
        all_quiet = 1'b1;
        for (int p = 0; p < NPL; p++)
            if (plane_mode_i[p*2 +: 2] inside {2'd1, 2'd2})
                all_quiet = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_hit   <= 1'b0;
            prev_plane <= '0;
            prev_mode  <= PL_IDLE;
            prev_b6    <= 1'b0;
        end else begin
            prev_hit   <= rd_strobe_i && mode_active(cur_mode);
            prev_plane <= rd_plane_i;
            prev_mode  <= cur_mode;
            prev_b6    <= rd_data_o[6];
        end
    end

    a_r1_prog_poll: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == PL_PROG) |-> (rd_data_o[7] == ~prog_data_i[7] && rd_data_o[2]));

    a_r2_erase_poll: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == PL_ERASE) |-> !rd_data_o[7]);

    a_r3_toggle_flip: assert property (@(posedge clk_i) disable iff (rst_i)
        (prev_hit && rd_plane_i == prev_plane && cur_mode == prev_mode) |-> (rd_data_o[6] != prev_b6));

    a_r5_susp_flags: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == PL_SUSP && rd_in_susp_i) |-> (rd_data_o[7:6] == 2'b11));

    a_r6_idle_true: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_mode == PL_IDLE) |-> (rd_data_o == array_data_i));

    a_r7_busy_on: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_active(cur_mode) |-> rdy_busy_oe_o);

    a_r7_busy_off: assert property (@(posedge clk_i) disable iff (rst_i)
        all_quiet |-> !rdy_busy_oe_o);

endmodule

bind emb_status_gen emb_status_chk #(.NPL(NPL), .DW(DW), .PLW(PLW)) i_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .plane_mode_i  (plane_mode_i),
    .rd_plane_i    (rd_plane_i),
    .rd_in_susp_i  (rd_in_susp_i),
    .rd_strobe_i   (rd_strobe_i),
    .prog_data_i   (prog_data_i),
    .array_data_i  (array_data_i),
    .rd_data_o     (rd_data_o),
    .rdy_busy_oe_o (rdy_busy_oe_o)
);

// File: tb/test_emb_status_gen.sv
module test_emb_status_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  plane_mode;
    logic        rd_plane;
    logic        rd_in_susp;
    logic        rd_strobe;
    logic [15:0] prog_data;
    logic [15:0] array_data;
    logic [15:0] rd_data;
    logic        busy_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    emb_status_gen i_emb_status_gen (
        .clk_i         (clk),
        .rst_i         (rst),
        .plane_mode_i  (plane_mode),
        .rd_plane_i    (rd_plane),
        .rd_in_susp_i  (rd_in_susp),
        .rd_strobe_i   (rd_strobe),
        .prog_data_i   (prog_data),
        .array_data_i  (array_data),
        .rd_data_o     (rd_data),
        .rdy_busy_oe_o (busy_oe)
    );

    // {mode1, mode0, plane, in_susp, prog, array, expected word, expected busy}
    localparam logic [54:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'hA5C3, 16'hA5C3, 1'b0}, // R6
        {2'd0, 2'd1, 1'b0, 1'b0, 16'h0080, 16'hFFFF, 16'h0004, 1'b1}, // R1 R9
        {2'd0, 2'd1, 1'b0, 1'b0, 16'h7F00, 16'hFFFF, 16'h0084, 1'b1}, // R1
        {2'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h1234, 16'h1234, 1'b1}, // R6 R7
        {2'd2, 2'd0, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 1'b1}, // R2 R9
        {2'd3, 2'd0, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h00C0, 1'b0}, // R5 R7
        {2'd3, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h5A5A, 16'h5A5A, 1'b0}, // R5
        {2'd1, 2'd2, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 1'b1}  // R2 R7
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] m1, input logic [1:0] m0, input logic pl,
                         input logic sus, input logic [15:0] pd, input logic [15:0] ad);
        @(negedge clk);
        plane_mode = {m1, m0};
        rd_plane   = pl;
        rd_in_susp = sus;
        prog_data  = pd;
        array_data = ad;
        #1;
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_strobe = 1'b0;
        plane_mode = 4'h0; rd_plane = 1'b0; rd_in_susp = 1'b0;
        prog_data = 16'h0000; array_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 reset word", rd_data, 16'hBEEF);
        chk("R7 reset busy", {15'd0, busy_oe}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][54:53], VEC[i][52:51], VEC[i][50], VEC[i][49], VEC[i][48:33], VEC[i][32:17]);
            chk($sformatf("R1-vector %0d word (R6 R9)", i), rd_data, VEC[i][16:1]);
            chk($sformatf("R7 vector %0d busy", i), {15'd0, busy_oe}, {15'd0, VEC[i][0]});
        end

        // program in plane 0: bit 6 flips per strobe, bit 2 stays 1
        apply(2'd0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'hFFFF);
        chk("R1 program start", rd_data, 16'h0084);
        pulse_read();
        chk("R3 first strobe", rd_data, 16'h00C4);
        pulse_read();
        chk("R4 second strobe bit2 held", rd_data, 16'h0084);

        // strobe in the idle plane must not move plane 0 toggles
        apply(2'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h3C3C);
        pulse_read();
        chk("R6 idle plane during strobe", rd_data, 16'h3C3C);
        apply(2'd0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'hFFFF);
        chk("R3 other-plane strobe ignored", rd_data, 16'h0084);

        // completion: same-cycle read returns data, toggles clear
        pulse_read();
        chk("R3 third strobe", rd_data, 16'h00C4);
        @(negedge clk);
        plane_mode = 4'h0; array_data = 16'h6E6E; rd_strobe = 1'b1;
        #1;
        chk("R6 read on completion cycle", rd_data, 16'h6E6E);
        chk("R7 released on completion", {15'd0, busy_oe}, 16'd0);
        @(negedge clk);
        rd_strobe = 1'b0;
        apply(2'd0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'hFFFF);
        chk("R8 toggle cleared after idle", rd_data, 16'h0084);

        // erase in plane 1: bits 6 and 2 flip together
        apply(2'd2, 2'd0, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
        chk("R2 erase start", rd_data, 16'h0000);
        pulse_read();
        chk("R4 erase strobe one", rd_data, 16'h0044);
        pulse_read();
        chk("R4 erase strobe two", rd_data, 16'h0000);

        // suspend
        apply(2'd3, 2'd0, 1'b1, 1'b1, 16'h0000, 16'hFFFF);
        chk("R5 suspended sector", rd_data, 16'h00C0);
        chk("R7 suspend not busy", {15'd0, busy_oe}, 16'd0);
        pulse_read();
        chk("R5 suspended strobe", rd_data, 16'h00C4);
        apply(2'd3, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0F0F);
        pulse_read();
        chk("R5 other sector true data", rd_data, 16'h0F0F);
        apply(2'd3, 2'd0, 1'b1, 1'b1, 16'h0000, 16'hFFFF);
        chk("R5 other-sector strobe ignored", rd_data, 16'h00C4);

        // resume keeps toggles, then finish clears
        apply(2'd2, 2'd0, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
        chk("R8 resume keeps toggles", rd_data, 16'h0004);
        chk("R7 busy after resume", {15'd0, busy_oe}, 16'd1);
        apply(2'd0, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h2468);
        chk("R6 erase done true data", rd_data, 16'h2468);
        apply(2'd2, 2'd0, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
        chk("R8 erase restart cleared", rd_data, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule